// File: doc/BRIEF.md
# Interrupt request mapper

This block gathers a wide set of independent interrupt request wires and steers each one onto a small set of outputs. There are fifteen request lines for a downstream interrupt controller and one system-management interrupt output. A per-source destination code picks the output for each source, and a per-source enable bit gates it. When several enabled sources share a destination, the output is their logical OR. Priority between sources is left to the downstream controller.

The request inputs may be asynchronous to the block clock, so they pass through a synchronizer first. The outputs are registered. A simple write port and a combinational read port reach the configuration and two status views: the raw synchronized state of every source, and that state after the enable mask.

Top module: `irq_router`

## Requirements
- R1: After reset every destination code reads 0, both enable words (addresses 0x40 and 0x41) read 0, and all fifteen request lines and the system-management output are low.
- R2: A source whose enable bit is 1 and whose destination code is k (1 to 15) drives request line bit k-1. That line goes high on the third rising clock edge after the source goes high (two synchronizer stages, then the output register).
- R3: A source with destination code 16 and its enable bit set drives the system-management output, with the same latency as R2.
- R4: Destination code 0 and codes 17 to 31 leave a source unrouted, so it reaches no output.
- R5: A source whose enable bit is 0 reaches no output whatever its destination code. Clearing the bit takes effect in the cycle after the write.
- R6: Each output is the OR of all enabled sources that share its destination code.
- R7: Raw status words read the synchronized source state regardless of mask and destination. Address 0x42 bit b is source b; address 0x43 bit b is source 32+b; bits 30 and 31 of 0x43 read 0.
- R8: Masked status words at 0x44 and 0x45 read the raw status ANDed with the enable bits, using the same bit layout as R7.
- R9: Address i (0 to 61) holds the 5-bit destination code of source i in bits 4:0, and the upper bits read 0. Address 0x40 holds the enable bits for sources 0 to 31, and 0x41 holds those for sources 32 to 61 in bits 29:0. Any other address reads 0.
- R10: No configuration register changes while the write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_src | input | 62 | Interrupt request sources, active high, may be asynchronous |
| wr_en | input | 1 | Write strobe for configuration registers |
| wr_addr | input | 7 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 7 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_line_o | output | 15 | Request lines to the interrupt controller, bit k-1 for code k |
| smi_o | output | 1 | System-management interrupt output |

## Verification
A corrupted destination code or enable bit shows up in two places. The affected request line rises or stays silent three edges after its source toggles, and the register readback differs at once. A fault in the synchronizer shows up in the raw status words two edges after an input change, before any output moves. The vectors place sources in both status words, on shared destinations and on illegal codes, so that a swapped index, a lost OR term or a wrong code decode reaches a distinct port value.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned DEST_W = 5;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned SRC_N  = 62;
  localparam int unsigned LINE_N = 15;

  function automatic int unsigned word_count(input int unsigned n);
    return (n + WORD_W - 1) / WORD_W;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stg_d[s] = d_i;
    end else begin : g_next
      assign stg_d[s] = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned NUM_SRC   = irq_router_pkg::SRC_N,
  parameter int unsigned DEST_W    = irq_router_pkg::DEST_W,
  parameter int unsigned WORD_W    = irq_router_pkg::WORD_W,
  parameter int unsigned ADDR_W    = irq_router_pkg::ADDR_W,
  parameter int unsigned MASK_BASE = 64,
  localparam int unsigned NUM_W    = irq_router_pkg::word_count(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [WORD_W-1:0]         wr_data,
  output logic [NUM_SRC*DEST_W-1:0] dest_flat,
  output logic [NUM_W*WORD_W-1:0]   en_pad
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_dest
    logic              we;
    logic [DEST_W-1:0] code_d;
    logic [DEST_W-1:0] code_q;
    assign we     = wr_en && (wr_addr == ADDR_W'(i));
    assign code_d = wr_data[DEST_W-1:0];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  code_q <= '0;
      else if (we) code_q <= code_d;
    end
    assign dest_flat[i*DEST_W +: DEST_W] = code_q;
  end

  for (genvar w = 0; w < NUM_W; w++) begin : g_mask
    logic              we;
    logic [WORD_W-1:0] m_d;
    logic [WORD_W-1:0] m_q;
    assign we = wr_en && (wr_addr == ADDR_W'(MASK_BASE + w));
    always_comb begin
      for (int b = 0; b < WORD_W; b++) begin
        m_d[b] = ((w * WORD_W + b) < NUM_SRC) ? wr_data[b] : 1'b0;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  m_q <= '0;
      else if (we) m_q <= m_d;
    end
    assign en_pad[w*WORD_W +: WORD_W] = m_q;
  end
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix #(
  parameter int unsigned NUM_SRC  = irq_router_pkg::SRC_N,
  parameter int unsigned NUM_DEST = irq_router_pkg::LINE_N + 1,
  parameter int unsigned DEST_W   = irq_router_pkg::DEST_W
) (
  input  logic [NUM_SRC-1:0]        act_i,
  input  logic [NUM_SRC*DEST_W-1:0] dest_flat,
  output logic [NUM_DEST-1:0]       hit_o
);
  // Output d collects every active source whose code equals d+1.
  for (genvar d = 0; d < NUM_DEST; d++) begin : g_out
    logic [NUM_SRC-1:0] match;
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign match[i] = act_i[i] &&
                        (dest_flat[i*DEST_W +: DEST_W] == DEST_W'(d + 1));
    end
    assign hit_o[d] = |match;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int unsigned NUM_SRC     = irq_router_pkg::SRC_N,
  parameter int unsigned NUM_LINES   = irq_router_pkg::LINE_N,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MASK_BASE   = 64,
  localparam int unsigned DEST_W     = irq_router_pkg::DEST_W,
  localparam int unsigned WORD_W     = irq_router_pkg::WORD_W,
  localparam int unsigned ADDR_W     = irq_router_pkg::ADDR_W,
  localparam int unsigned NUM_W      = irq_router_pkg::word_count(NUM_SRC),
  localparam int unsigned RAW_BASE   = MASK_BASE + NUM_W,
  localparam int unsigned MSKD_BASE  = RAW_BASE + NUM_W,
  localparam int unsigned NUM_DEST   = NUM_LINES + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_src,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [WORD_W-1:0]    rd_data,
  output logic [NUM_LINES-1:0] irq_line_o,
  output logic                 smi_o
);
  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q;
  logic rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_SRC-1:0]        src_sync;
  logic [NUM_SRC*DEST_W-1:0] dest_flat;
  logic [NUM_W*WORD_W-1:0]   en_pad;
  logic [NUM_W*WORD_W-1:0]   raw_pad;
  logic [NUM_W*WORD_W-1:0]   mskd_pad;
  logic [NUM_SRC-1:0]        src_act;
  logic [NUM_DEST-1:0]       hit;
  logic [NUM_DEST-1:0]       out_d;
  logic [NUM_DEST-1:0]       out_q;

  irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (irq_src),
    .q_o   (src_sync)
  );

  irq_cfg_regs #(
    .NUM_SRC(NUM_SRC), .DEST_W(DEST_W), .WORD_W(WORD_W),
    .ADDR_W(ADDR_W), .MASK_BASE(MASK_BASE)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .dest_flat (dest_flat),
    .en_pad    (en_pad)
  );

  assign raw_pad  = (NUM_W*WORD_W)'(src_sync);
  assign mskd_pad = raw_pad & en_pad;
  assign src_act  = mskd_pad[NUM_SRC-1:0];

  irq_route_matrix #(
    .NUM_SRC(NUM_SRC), .NUM_DEST(NUM_DEST), .DEST_W(DEST_W)
  ) u_matrix (
    .act_i     (src_act),
    .dest_flat (dest_flat),
    .hit_o     (hit)
  );

  // Output register: next state and storage kept apart.
  assign out_d = hit;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_q <= '0;
    else             out_q <= out_d;
  end

  assign irq_line_o = out_q[NUM_LINES-1:0];
  assign smi_o      = out_q[NUM_LINES];

  // Read mux.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = WORD_W'(dest_flat[i*DEST_W +: DEST_W]);
    end
    for (int w = 0; w < NUM_W; w++) begin
      if (rd_addr == ADDR_W'(MASK_BASE + w)) rd_data = en_pad[w*WORD_W +: WORD_W];
      if (rd_addr == ADDR_W'(RAW_BASE + w))  rd_data = raw_pad[w*WORD_W +: WORD_W];
      if (rd_addr == ADDR_W'(MSKD_BASE + w)) rd_data = mskd_pad[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int unsigned NUM_SRC   = irq_router_pkg::SRC_N,
  parameter int unsigned NUM_LINES = irq_router_pkg::LINE_N,
  parameter int unsigned DEST_W    = irq_router_pkg::DEST_W
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [NUM_SRC-1:0]        src_sync,
  input logic [NUM_SRC-1:0]        en_mask,
  input logic [NUM_SRC*DEST_W-1:0] dest_flat,
  input logic [NUM_LINES-1:0]      irq_line_o,
  input logic                      smi_o
);
  localparam logic [DEST_W-1:0] SMI_CODE = DEST_W'(NUM_LINES + 1);

  logic any_line;
  logic any_smi;
  always_comb begin
    any_line = 1'b0;
    any_smi  = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_sync[i] && en_mask[i]) begin
        if (dest_flat[i*DEST_W +: DEST_W] == SMI_CODE) any_smi = 1'b1;
        if (dest_flat[i*DEST_W +: DEST_W] != '0 &&
            dest_flat[i*DEST_W +: DEST_W] <  SMI_CODE) any_line = 1'b1;
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_mask == '0 && dest_flat == '0 && irq_line_o == '0 && !smi_o));

  p_line_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_line_o) |-> $past(any_line));

  p_smi_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |-> $past(any_smi));

  p_unrouted_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(any_line || any_smi) |-> (irq_line_o == '0 && !smi_o));

  p_masked_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_mask) == '0) |-> (irq_line_o == '0 && !smi_o));

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(en_mask) && $stable(dest_flat)));
endmodule

bind irq_router irq_router_chk #(
  .NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES), .DEST_W(DEST_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .src_sync   (src_sync),
  .en_mask    (en_pad[NUM_SRC-1:0]),
  .dest_flat  (dest_flat),
  .irq_line_o (irq_line_o),
  .smi_o      (smi_o)
);

// File: tb/test_irq_router.sv
module test_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [61:0] irq_src = '0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [14:0] irq_line_o;
  logic        smi_o;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  irq_router i_irq_router (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_line_o(irq_line_o), .smi_o(smi_o)
  );

  typedef struct packed {
    logic [61:0] src;
    logic [14:0] line;
    logic        smi;
    logic [3:0]  req;
  } vec_t;

  // Configuration used by the table: src0,src1 -> code 1; src5,src50 -> 15;
  // src10,src61 -> 16; src20 -> 3 but disabled; src33 -> 7; src40 -> 0; src41 -> 20.
  localparam vec_t VECS [12] = '{
    '{62'h0,                   15'h0000, 1'b0, 4'd1},  // R1 idle
    '{62'h1,                   15'h0001, 1'b0, 4'd2},  // R2
    '{62'h2,                   15'h0001, 1'b0, 4'd2},  // R2
    '{62'h3,                   15'h0001, 1'b0, 4'd6},  // R6
    '{62'h20,                  15'h4000, 1'b0, 4'd2},  // R2 code 15
    '{62'h400,                 15'h0000, 1'b1, 4'd3},  // R3
    '{62'h100000,              15'h0000, 1'b0, 4'd5},  // R5
    '{62'h2_0000_0000,         15'h0040, 1'b0, 4'd2},  // R2 upper word
    '{62'h2000_0000_0000_0000, 15'h0000, 1'b1, 4'd3},  // R3 top source
    '{62'h300_0000_0000,       15'h0000, 1'b0, 4'd4},  // R4 codes 0 and 20
    '{62'h4_0000_0000_0020,    15'h4000, 1'b0, 4'd6},  // R6
    '{{62{1'b1}},              15'h4041, 1'b1, 4'd6}   // R6 all
  };

  localparam logic [61:0] EN_EXP = {30'h2004_0302, 32'h0000_0423};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic apply(input logic [61:0] s);
    @(negedge clk);
    irq_src = s;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [61:0] exp_m;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 lines", 64'(irq_line_o), 64'h0);
    check("R1 smi", 64'(smi_o), 64'h0);
    rd(7'd10, v);   check("R1 dest", 64'(v), 64'h0);
    rd(7'h40, v);   check("R1 mask lo", 64'(v), 64'h0);
    rd(7'h41, v);   check("R1 mask hi", 64'(v), 64'h0);

    // Enabled but unrouted after reset: R1 R4
    wr(7'h40, 32'hFFFF_FFFF);
    apply(62'h1);
    check("R4 unrouted after reset", 64'({irq_line_o, smi_o}), 64'h0);
    apply(62'h0);

    wr(7'd0, 32'd1);  wr(7'd1, 32'd1);  wr(7'd5, 32'd15);
    wr(7'd10, 32'd16); wr(7'd20, 32'd3); wr(7'd33, 32'd7);
    wr(7'd61, 32'd16); wr(7'd40, 32'd0); wr(7'd41, 32'd20);
    wr(7'd50, 32'd15);
    wr(7'h40, 32'h0000_0423);
    wr(7'h41, 32'hE004_0302);  // bits 31:30 are not stored (R9)

    foreach (VECS[k]) begin
      apply(VECS[k].src);
      exp_m = VECS[k].src & EN_EXP;
      if (irq_line_o !== VECS[k].line || smi_o !== VECS[k].smi) begin
        fails++;
        $display("FAIL R%0d vector %0d actual=%h/%b expected=%h/%b",
                 VECS[k].req, k, irq_line_o, smi_o, VECS[k].line, VECS[k].smi);
      end
      tests++;
      rd(7'h42, v); check("R7 raw lo",  64'(v), 64'(VECS[k].src[31:0]));
      rd(7'h43, v); check("R7 raw hi",  64'(v), 64'({2'b00, VECS[k].src[61:32]}));
      rd(7'h44, v); check("R8 mskd lo", 64'(v), 64'(exp_m[31:0]));
      rd(7'h45, v); check("R8 mskd hi", 64'(v), 64'({2'b00, exp_m[61:32]}));
    end

    // R9 readback
    rd(7'd5, v);   check("R9 dest 5", 64'(v), 64'd15);
    rd(7'd41, v);  check("R9 dest 41", 64'(v), 64'd20);
    rd(7'h41, v);  check("R9 mask hi", 64'(v), 64'h2004_0302);
    rd(7'h50, v);  check("R9 unmapped", 64'(v), 64'h0);
    rd(7'h46, v);  check("R9 unmapped 46", 64'(v), 64'h0);

    // R10: data on the bus with the strobe low
    @(negedge clk);
    wr_addr = 7'd5; wr_data = 32'd3; wr_en = 1'b0;
    @(negedge clk);
    rd(7'd5, v);   check("R10 dest hold", 64'(v), 64'd15);
    wr_addr = 7'h40; wr_data = 32'h0;
    @(negedge clk);
    rd(7'h40, v);  check("R10 mask hold", 64'(v), 64'h423);

    // R5: clearing an enable bit while its source is high
    apply(62'h400);
    check("R5 smi before clear", 64'(smi_o), 64'h1);
    wr(7'h40, 32'h0000_0023);
    @(negedge clk);
    check("R5 smi after clear", 64'(smi_o), 64'h0);
    rd(7'h44, v);  check("R5 masked status", 64'(v), 64'h0);

    // R2: retarget a live source and see the move
    wr(7'd0, 32'd9);
    apply(62'h1);
    check("R2 retarget", 64'(irq_line_o), 64'h0100);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule